// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks translation tables that sit in physical memory. It starts from a per-context root entry and then descends through up to three table levels. At each level the fetched word names itself as one of four things: an invalid slot, a pointer to the next table, a final page mapping, or a reserved value. A page mapping may appear at the first, second or third level. It then maps a 16 MB, 256 KB or 4 KB region. Any other outcome ends the walk with a fault code. The code records the level reached and the kind of error.

A requester hands over one address at a time on a valid/ready channel. It collects the result on a second valid/ready channel. All table traffic goes through a single word-wide memory port, which allows one transfer in flight and waits for an acknowledge. On a successful walk the block marks the final entry as referenced, and as modified on a store. It writes the entry back only when one of those two bits actually flips. Permission checking, fault bookkeeping and any caching of results belong to the surrounding logic. When translation is switched off, addresses pass straight through and memory is left alone.

Top module: `xlat_walker`

## Requirements
- R1: With `cfg_enable` low, an accepted request produces a response with `rsp_paddr` equal to the virtual address zero-extended to 36 bits, `rsp_bypass`=1, `rsp_wr_ok`=1, `rsp_acc`=0 and `rsp_fault`=0, and no memory transfer takes place.
- R2: With `cfg_enable` high, the first memory read of a walk is at address `cfg_root_ptr`*16 + `cfg_ctx`*4.
- R3: Bits [1:0] of each fetched word give its kind: 0 invalid, 1 table pointer, 2 page mapping, 3 reserved. For a table pointer fetched at level L (level 0 is the context root), the next read is at `{word[31:2], 6'b0}` + 4*index. The index is va[31:24] for level 1, va[23:18] for level 2 and va[17:12] for level 3.
- R4: A page mapping found at level 1, 2 or 3 gives `rsp_paddr` = `{word[31:8], 12'b0}` + offset, where the offset is va[23:0], va[17:0] or va[11:0] respectively. `rsp_acc` = word[4:2] and `rsp_bypass`=0.
- R5: An invalid word fetched at level L ends the walk with `rsp_fault` = (L<<8) | (1<<2).
- R6: A reserved word at any level, a page mapping at level 0, or a table pointer at level 3 ends the walk with `rsp_fault` = (L<<8) | (4<<2).
- R7: On a successful walk the block sets bit 5 (referenced) of the final word, and on a store also bit 6 (modified). The updated word is written back to the address it was read from only if it differs from the fetched word. A faulting walk writes nothing.
- R8: `rsp_wr_ok` equals the modified bit of the final word after the update, so a load through a page not yet modified returns 0.
- R9: `req_ready` is high only while no walk or response is pending. `rsp_valid` and every response field stay constant until `rsp_ready` is seen high.
- R10: While `mem_req` is high and `mem_ack` low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Translation on (1) or pass-through (0) |
| cfg_root_ptr | input | CTP_W | Root table pointer, in 16-byte units |
| cfg_ctx | input | CTX_W | Current context number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is for a store |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 36 | Physical address |
| rsp_acc | output | 3 | Access field of the final word |
| rsp_wr_ok | output | 1 | Stores may use this mapping without another walk |
| rsp_bypass | output | 1 | Result came from pass-through with full rights |
| rsp_fault | output | 10 | Zero on success, else level and error kind |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 36 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume three things about the inputs. `cfg_enable`, `cfg_root_ptr` and `cfg_ctx` stay constant from the cycle a request is accepted until its result is taken. `mem_ack` is a single-cycle pulse raised only while `mem_req` is high. `mem_rdata` is valid in that same cycle. The stimulus meets these by changing the configuration only between complete request/response pairs. Its memory model answers each transfer with one registered acknowledge after a fixed delay and stays silent in the cycle after an acknowledge.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;
  localparam int VA_W      = 32;
  localparam int ENT_W     = 32;
  localparam int PA_W      = ENT_W + 4;
  localparam int LVL_W     = 2;
  localparam int LAST_LVL  = 3;
  localparam int ACC_LSB   = 2;
  localparam int ACC_W     = 3;
  localparam int REF_BIT   = 5;
  localparam int MOD_BIT   = 6;
  localparam int PPN_LSB   = 8;
  localparam int PG_SHIFT  = 12;
  localparam int KIND_W    = 6;
  localparam int FLT_W     = LVL_W + KIND_W + 2;

  typedef enum logic [1:0] {
    ET_EMPTY = 2'd0,
    ET_TABLE = 2'd1,
    ET_PAGE  = 2'd2,
    ET_RSVD  = 2'd3
  } ent_kind_e;

  typedef enum logic [1:0] {
    DK_DESCEND = 2'd0,
    DK_LEAF    = 2'd1,
    DK_FAULT   = 2'd2
  } dec_kind_e;

  localparam logic [KIND_W-1:0] FK_EMPTY = KIND_W'(1);
  localparam logic [KIND_W-1:0] FK_BAD   = KIND_W'(4);

  function automatic logic [FLT_W-1:0] mk_fault(input logic [LVL_W-1:0] lvl,
                                                input logic [KIND_W-1:0] kind);
    return {lvl, kind, 2'b00};
  endfunction
endpackage

// File: rtl/xw_rst_sync.sv
`timescale 1ns/1ps
module xw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int MSB = STAGES - 1;
  logic [MSB:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[MSB];
endmodule

// File: rtl/xw_addr_gen.sv
`timescale 1ns/1ps
module xw_addr_gen
  import xw_pkg::*;
#(
  parameter int CTP_W = 32,
  parameter int CTX_W = 8
) (
  input  logic [CTP_W-1:0]  root_ptr,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [19:0]       va_hi,      // va[31:12]
  input  logic [ENT_W-1:0]  desc,
  input  logic [LVL_W-1:0]  lvl_next,
  output logic [PA_W-1:0]   root_addr,
  output logic [PA_W-1:0]   next_addr
);
  localparam int IDX_W = 8;
  localparam logic [ENT_W-1:0] TYPE_MASK = ~ENT_W'(3);

  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  base;

  assign root_addr = PA_W'({root_ptr, 4'b0000}) + PA_W'({ctx, 2'b00});

  always_comb begin
    unique case (lvl_next)
      2'd1:    idx = va_hi[19:12];                 // va[31:24]
      2'd2:    idx = {2'b00, va_hi[11:6]};         // va[23:18]
      2'd3:    idx = {2'b00, va_hi[5:0]};          // va[17:12]
      default: idx = '0;
    endcase
  end

  assign base      = {desc & TYPE_MASK, 4'b0000};
  assign next_addr = base + PA_W'({idx, 2'b00});
endmodule

// File: rtl/xw_entry_dec.sv
`timescale 1ns/1ps
module xw_entry_dec
  import xw_pkg::*;
(
  input  logic [ENT_W-1:0]  entry,
  input  logic [LVL_W-1:0]  lvl,
  input  logic              is_write,
  input  logic [23:0]       va_lo,      // va[23:0]
  output dec_kind_e         kind,
  output logic [FLT_W-1:0]  fault,
  output logic [ENT_W-1:0]  new_entry,
  output logic              need_wb,
  output logic [PA_W-1:0]   paddr,
  output logic [ACC_W-1:0]  acc,
  output logic              wr_ok
);
  ent_kind_e        ek;
  logic [23:0]      offset;
  logic [ENT_W-1:0] set_bits;

  assign ek = ent_kind_e'(entry[1:0]);

  always_comb begin
    kind  = DK_FAULT;
    fault = '0;
    unique case (ek)
      ET_EMPTY: fault = mk_fault(lvl, FK_EMPTY);
      ET_RSVD:  fault = mk_fault(lvl, FK_BAD);
      ET_TABLE: begin
        if (lvl == LVL_W'(LAST_LVL)) fault = mk_fault(lvl, FK_BAD);
        else                         kind  = DK_DESCEND;
      end
      ET_PAGE: begin
        if (lvl == '0) fault = mk_fault(lvl, FK_BAD);
        else           kind  = DK_LEAF;
      end
      default: fault = mk_fault(lvl, FK_BAD);
    endcase
  end

  // Page size follows the level at which the mapping was found.
  always_comb begin
    unique case (lvl)
      2'd1:    offset = va_lo;
      2'd2:    offset = {6'b0, va_lo[17:0]};
      default: offset = {12'b0, va_lo[11:0]};
    endcase
  end

  always_comb begin
    set_bits          = '0;
    set_bits[REF_BIT] = 1'b1;
    set_bits[MOD_BIT] = is_write;
  end

  assign new_entry = entry | set_bits;
  assign need_wb   = (new_entry != entry);
  assign wr_ok     = new_entry[MOD_BIT];
  assign acc       = entry[ACC_LSB +: ACC_W];
  assign paddr     = {entry[ENT_W-1:PPN_LSB], PG_SHIFT'(0)} + PA_W'(offset);
endmodule

// File: rtl/xw_walk_ctrl.sv
`timescale 1ns/1ps
module xw_walk_ctrl
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [ACC_W-1:0]  rsp_acc,
  output logic              rsp_wr_ok,
  output logic              rsp_bypass,
  output logic [FLT_W-1:0]  rsp_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  // shared with address generator and decoder
  output logic [VA_W-1:0]   cur_va,
  output logic              cur_write,
  output logic [LVL_W-1:0]  cur_lvl,
  output logic [LVL_W-1:0]  lvl_next,
  input  logic [PA_W-1:0]   root_addr,
  input  logic [PA_W-1:0]   next_addr,
  input  dec_kind_e         dec_kind,
  input  logic [FLT_W-1:0]  dec_fault,
  input  logic [ENT_W-1:0]  dec_new_entry,
  input  logic              dec_need_wb,
  input  logic [PA_W-1:0]   dec_paddr,
  input  logic [ACC_W-1:0]  dec_acc,
  input  logic              dec_wr_ok
);
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_READ = 2'd1,
    S_WB   = 2'd2,
    S_RSP  = 2'd3
  } st_e;

  st_e              st_q, st_d;
  logic [VA_W-1:0]  va_q, va_d;
  logic             wr_q, wr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [PA_W-1:0]  maddr_q, maddr_d;
  logic [ENT_W-1:0] wdata_q, wdata_d;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             wrok_q, wrok_d;
  logic             byp_q, byp_d;
  logic [FLT_W-1:0] flt_q, flt_d;

  logic take_req, ld_req, ld_walk, ld_rsp;

  assign take_req = (st_q == S_IDLE) && req_valid;

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d    = st_q;
    va_d    = va_q;
    wr_d    = wr_q;
    lvl_d   = lvl_q;
    maddr_d = maddr_q;
    wdata_d = wdata_q;
    paddr_d = paddr_q;
    acc_d   = acc_q;
    wrok_d  = wrok_q;
    byp_d   = byp_q;
    flt_d   = flt_q;
    ld_req  = 1'b0;
    ld_walk = 1'b0;
    ld_rsp  = 1'b0;

    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          va_d   = req_vaddr;
          wr_d   = req_write;
          lvl_d  = '0;
          if (!enable) begin
            ld_rsp  = 1'b1;
            paddr_d = PA_W'(req_vaddr);
            acc_d   = '0;
            wrok_d  = 1'b1;
            byp_d   = 1'b1;
            flt_d   = '0;
            st_d    = S_RSP;
          end else begin
            ld_walk = 1'b1;
            maddr_d = root_addr;
            st_d    = S_READ;
          end
        end
      end

      S_READ: begin
        if (mem_ack) begin
          unique case (dec_kind)
            DK_DESCEND: begin
              ld_walk = 1'b1;
              maddr_d = next_addr;
              lvl_d   = lvl_q + LVL_W'(1);
            end
            DK_LEAF: begin
              ld_rsp  = 1'b1;
              paddr_d = dec_paddr;
              acc_d   = dec_acc;
              wrok_d  = dec_wr_ok;
              byp_d   = 1'b0;
              flt_d   = '0;
              if (dec_need_wb) begin
                ld_walk = 1'b1;
                wdata_d = dec_new_entry;
                st_d    = S_WB;
              end else begin
                st_d    = S_RSP;
              end
            end
            default: begin
              ld_rsp  = 1'b1;
              paddr_d = '0;
              acc_d   = '0;
              wrok_d  = 1'b0;
              byp_d   = 1'b0;
              flt_d   = dec_fault;
              st_d    = S_RSP;
            end
          endcase
        end
      end

      S_WB: begin
        if (mem_ack) st_d = S_RSP;
      end

      S_RSP: begin
        if (rsp_ready) st_d = S_IDLE;
      end

      default: st_d = S_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q <= '0;
      wr_q <= 1'b0;
    end else if (ld_req) begin
      va_q <= va_d;
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      maddr_q <= '0;
      wdata_q <= '0;
    end else if (ld_req || ld_walk) begin
      lvl_q   <= lvl_d;
      maddr_q <= maddr_d;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      acc_q   <= '0;
      wrok_q  <= 1'b0;
      byp_q   <= 1'b0;
      flt_q   <= '0;
    end else if (ld_rsp) begin
      paddr_q <= paddr_d;
      acc_q   <= acc_d;
      wrok_q  <= wrok_d;
      byp_q   <= byp_d;
      flt_q   <= flt_d;
    end
  end

  // ---------------- outputs ----------------
  assign req_ready  = (st_q == S_IDLE);
  assign rsp_valid  = (st_q == S_RSP);
  assign rsp_paddr  = paddr_q;
  assign rsp_acc    = acc_q;
  assign rsp_wr_ok  = wrok_q;
  assign rsp_bypass = byp_q;
  assign rsp_fault  = flt_q;
  assign mem_req    = (st_q == S_READ) || (st_q == S_WB);
  assign mem_we     = (st_q == S_WB);
  assign mem_addr   = maddr_q;
  assign mem_wdata  = wdata_q;
  assign cur_va     = va_q;
  assign cur_write  = wr_q;
  assign cur_lvl    = lvl_q;
  assign lvl_next   = lvl_q + LVL_W'(1);

  logic unused_take;
  assign unused_take = take_req;
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
  import xw_pkg::*;
#(
  parameter int CTP_W = 32,
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [CTP_W-1:0]  cfg_root_ptr,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [35:0]       rsp_paddr,
  output logic [2:0]        rsp_acc,
  output logic              rsp_wr_ok,
  output logic              rsp_bypass,
  output logic [9:0]        rsp_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [35:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);
  logic             rst_n_i;
  logic [VA_W-1:0]  cur_va;
  logic             cur_write;
  logic [LVL_W-1:0] cur_lvl, lvl_next;
  logic [PA_W-1:0]  root_addr, next_addr;
  dec_kind_e        dec_kind;
  logic [FLT_W-1:0] dec_fault;
  logic [ENT_W-1:0] dec_new_entry;
  logic             dec_need_wb;
  logic [PA_W-1:0]  dec_paddr;
  logic [ACC_W-1:0] dec_acc;
  logic             dec_wr_ok;

  xw_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  xw_addr_gen #(.CTP_W(CTP_W), .CTX_W(CTX_W)) addr_gen_i (
    .root_ptr  (cfg_root_ptr),
    .ctx       (cfg_ctx),
    .va_hi     (cur_va[31:12]),
    .desc      (mem_rdata),
    .lvl_next  (lvl_next),
    .root_addr (root_addr),
    .next_addr (next_addr)
  );

  xw_entry_dec entry_dec_i (
    .entry     (mem_rdata),
    .lvl       (cur_lvl),
    .is_write  (cur_write),
    .va_lo     (cur_va[23:0]),
    .kind      (dec_kind),
    .fault     (dec_fault),
    .new_entry (dec_new_entry),
    .need_wb   (dec_need_wb),
    .paddr     (dec_paddr),
    .acc       (dec_acc),
    .wr_ok     (dec_wr_ok)
  );

  xw_walk_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .enable        (cfg_enable),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_acc       (rsp_acc),
    .rsp_wr_ok     (rsp_wr_ok),
    .rsp_bypass    (rsp_bypass),
    .rsp_fault     (rsp_fault),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .cur_va        (cur_va),
    .cur_write     (cur_write),
    .cur_lvl       (cur_lvl),
    .lvl_next      (lvl_next),
    .root_addr     (root_addr),
    .next_addr     (next_addr),
    .dec_kind      (dec_kind),
    .dec_fault     (dec_fault),
    .dec_new_entry (dec_new_entry),
    .dec_need_wb   (dec_need_wb),
    .dec_paddr     (dec_paddr),
    .dec_acc       (dec_acc),
    .dec_wr_ok     (dec_wr_ok)
  );
endmodule

// File: rtl/xw_checker.sv
`timescale 1ns/1ps
module xw_checker #(
  parameter int CTP_W = 32,
  parameter int CTX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_enable,
  input logic [CTP_W-1:0] cfg_root_ptr,
  input logic [CTX_W-1:0] cfg_ctx,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_vaddr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [35:0]      rsp_paddr,
  input logic             rsp_wr_ok,
  input logic             rsp_bypass,
  input logic [9:0]       rsp_fault,
  input logic             mem_req,
  input logic             mem_we,
  input logic [35:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             mem_ack
);
  logic [35:0] root_exp;
  assign root_exp = 36'({cfg_root_ptr, 4'b0000}) + 36'({cfg_ctx, 2'b00});

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_enable) |=>
      (rsp_valid && rsp_bypass && rsp_wr_ok && !mem_req &&
       rsp_fault == 10'd0 && rsp_paddr == {4'b0000, $past(req_vaddr)}));

  p_root_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_enable) |=>
      (mem_req && !mem_we && mem_addr == $past(root_exp)));

  p_fault_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 10'd0) |->
      (rsp_fault[1:0] == 2'b00 && (rsp_fault[7:2] == 6'd1 || rsp_fault[7:2] == 6'd4)
       && !rsp_bypass && !rsp_wr_ok));

  p_wb_marks_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_wr_ok)));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind xlat_walker xw_checker #(.CTP_W(CTP_W), .CTX_W(CTX_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n_i),
  .cfg_enable   (cfg_enable),
  .cfg_root_ptr (cfg_root_ptr),
  .cfg_ctx      (cfg_ctx),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_wr_ok    (rsp_wr_ok),
  .rsp_bypass   (rsp_bypass),
  .rsp_fault    (rsp_fault),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack)
);

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;
  localparam int LAT     = 2;
  localparam int WD_CYC  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [31:0] cfg_root_ptr = '0;
  logic [7:0]  cfg_ctx = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [35:0] rsp_paddr;
  logic [2:0]  rsp_acc;
  logic        rsp_wr_ok;
  logic        rsp_bypass;
  logic [9:0]  rsp_fault;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_root_ptr(cfg_root_ptr),
    .cfg_ctx(cfg_ctx), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_acc(rsp_acc),
    .rsp_wr_ok(rsp_wr_ok), .rsp_bypass(rsp_bypass), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [logic [35:0]];
  logic [35:0] rd_log [int];
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [35:0] last_wa = '0;
  int          lat_cnt = 0;
  logic        poke_en = 1'b0;
  logic [35:0] poke_a = '0;
  logic [31:0] poke_d = '0;

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (poke_en) mem[poke_a] = poke_d;
    if (mem_req && !mem_ack) begin
      if (lat_cnt == LAT) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          last_wa <= mem_addr;
          wr_cnt  <= wr_cnt + 1;
        end else begin
          mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          rd_log[rd_cnt] = mem_addr;
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  function automatic logic [31:0] peek(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // ---------------- reference helpers ----------------
  function automatic logic [35:0] root_of(input logic [31:0] ctp, input logic [7:0] ctx);
    return {4'b0, ctp} * 16 + {28'b0, ctx} * 4;
  endfunction

  function automatic logic [35:0] child_of(input logic [31:0] d, input int lvl,
                                           input logic [31:0] va);
    logic [35:0] base;
    logic [35:0] idx;
    base = {d[31:2], 6'b0};
    idx  = (lvl == 1) ? {28'b0, va[31:24]} : (lvl == 2) ? {30'b0, va[23:18]} : {30'b0, va[17:12]};
    return base + idx * 4;
  endfunction

  function automatic logic [31:0] ptr_to(input logic [35:0] tbl);
    return tbl[35:4] | 32'h1;
  endfunction

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [35:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  logic [35:0] c_paddr;
  logic [2:0]  c_acc;
  logic        c_wrok, c_byp;
  logic [9:0]  c_flt;
  int          rd0, wr0;

  task automatic do_req(input logic [31:0] va, input logic wr, input int hold);
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1; rsp_ready = (hold == 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    c_paddr = rsp_paddr; c_acc = rsp_acc; c_wrok = rsp_wr_ok;
    c_byp = rsp_bypass; c_flt = rsp_fault;
    if (hold > 0) begin
      repeat (hold) begin
        @(negedge clk);
        check("R9 rsp_valid held", {35'b0, rsp_valid}, 36'd1);
        check("R9 req_ready low while pending", {35'b0, req_ready}, 36'd0);
        check("R9 paddr stable", rsp_paddr, c_paddr);
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // ---------------- table layout ----------------
  localparam logic [31:0] CTP   = 32'h0000_1000;
  localparam logic [35:0] T1    = 36'h2_0000;
  localparam logic [35:0] T2    = 36'h3_0000;
  localparam logic [35:0] T3    = 36'h4_0000;
  localparam logic [35:0] T2B   = 36'h5_0000;
  localparam logic [31:0] VA_A  = 32'h40C5_3ABC;
  localparam logic [31:0] VA_B  = 32'h40FF_F123;
  localparam logic [31:0] VA_C  = 32'h80AB_CDEF;
  localparam logic [31:0] PTE_A = {24'h0ABCDE, 8'h0E};
  localparam logic [31:0] PTE_B = {24'h000400, 8'h26};
  localparam logic [31:0] PTE_C = {24'h012345, 8'h62};

  task automatic build_tables();
    poke(root_of(CTP, 8'd5), ptr_to(T1));
    poke(root_of(CTP, 8'd7), 32'h0000_0002);
    poke(child_of(ptr_to(T1), 1, VA_A), ptr_to(T2));
    poke(child_of(ptr_to(T2), 2, VA_A), ptr_to(T3));
    poke(child_of(ptr_to(T3), 3, VA_A), PTE_A);
    poke(child_of(ptr_to(T2), 2, VA_B), PTE_B);
    poke(child_of(ptr_to(T1), 1, VA_C), PTE_C);
    poke(child_of(ptr_to(T1), 1, 32'h4200_0000), ptr_to(T2B));
    poke(T2B, 32'h0000_0003);
    poke(child_of(ptr_to(T3), 3, 32'h40C4_0000), 32'h0000_6001);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R9 ready after reset", {35'b0, req_ready}, 36'd1);
    check("R9 no response after reset", {35'b0, rsp_valid}, 36'd0);
    check("R10 memory idle after reset", {35'b0, mem_req}, 36'd0);
  endtask

  task automatic t_bypass();
    cfg_enable = 1'b0;
    do_req(32'hDEAD_BEEF, 1'b0, 0);
    check("R1 paddr passthrough", c_paddr, 36'h0_DEAD_BEEF);
    check("R1 bypass flag", {35'b0, c_byp}, 36'd1);
    check("R1 write allowed", {35'b0, c_wrok}, 36'd1);
    check("R1 no fault", {26'b0, c_flt}, 36'd0);
    check("R1 no memory reads", rd_cnt - rd0, 0);
    cfg_enable = 1'b1;
  endtask

  task automatic t_l3_load();
    logic [35:0] pa;
    do_req(VA_A, 1'b0, 0);
    check("R2 first read address", rd_log[rd0], root_of(CTP, 8'd5));
    check("R3 level-1 read address", rd_log[rd0+1], child_of(ptr_to(T1), 1, VA_A));
    check("R3 level-2 read address", rd_log[rd0+2], child_of(ptr_to(T2), 2, VA_A));
    check("R3 level-3 read address", rd_log[rd0+3], child_of(ptr_to(T3), 3, VA_A));
    check("R3 four reads", rd_cnt - rd0, 4);
    pa = {PTE_A[31:8], 12'b0} + {24'b0, VA_A[11:0]};
    check("R4 4KB paddr", c_paddr, pa);
    check("R4 acc field", {33'b0, c_acc}, 36'd3);
    check("R4 not bypass", {35'b0, c_byp}, 36'd0);
    check("R7 one write-back", wr_cnt - wr0, 1);
    check("R7 wb address", last_wa, child_of(ptr_to(T3), 3, VA_A));
    check("R7 referenced set", {4'b0, peek(child_of(ptr_to(T3), 3, VA_A))}, {4'b0, PTE_A | 32'h20});
    check("R8 load on unmodified page", {35'b0, c_wrok}, 36'd0);
  endtask

  task automatic t_l3_store();
    do_req(VA_A, 1'b1, 0);
    check("R7 store write-back", wr_cnt - wr0, 1);
    check("R7 modified set", {4'b0, peek(child_of(ptr_to(T3), 3, VA_A))}, {4'b0, PTE_A | 32'h60});
    check("R8 store gives wr_ok", {35'b0, c_wrok}, 36'd1);
    do_req(VA_A, 1'b1, 0);
    check("R7 no write when unchanged", wr_cnt - wr0, 0);
    check("R8 modified page wr_ok", {35'b0, c_wrok}, 36'd1);
  endtask

  task automatic t_large();
    do_req(VA_B, 1'b0, 0);
    check("R4 256KB paddr", c_paddr, {PTE_B[31:8], 12'b0} + {18'b0, VA_B[17:0]});
    check("R4 256KB acc", {33'b0, c_acc}, 36'd1);
    check("R3 three reads", rd_cnt - rd0, 3);
    check("R7 no write, ref already set", wr_cnt - wr0, 0);
    do_req(VA_C, 1'b1, 0);
    check("R4 16MB paddr", c_paddr, {PTE_C[31:8], 12'b0} + {12'b0, VA_C[23:0]});
    check("R7 no write, both bits set", wr_cnt - wr0, 0);
    check("R8 16MB wr_ok", {35'b0, c_wrok}, 36'd1);
  endtask

  task automatic t_faults();
    cfg_ctx = 8'd6;
    do_req(VA_A, 1'b0, 0);
    check("R5 empty root", {26'b0, c_flt}, 36'h004);
    check("R5 one read", rd_cnt - rd0, 1);
    cfg_ctx = 8'd7;
    do_req(VA_A, 1'b0, 0);
    check("R6 page at root", {26'b0, c_flt}, 36'h010);
    cfg_ctx = 8'd5;
    do_req(32'h4100_0000, 1'b1, 0);
    check("R5 empty level 1", {26'b0, c_flt}, 36'h104);
    check("R7 fault writes nothing", wr_cnt - wr0, 0);
    do_req(32'h4200_0000, 1'b0, 0);
    check("R6 reserved level 2", {26'b0, c_flt}, 36'h210);
    do_req(32'h40C4_0000, 1'b0, 0);
    check("R6 table at level 3", {26'b0, c_flt}, 36'h310);
    do_req(32'h40C4_1000, 1'b0, 0);
    check("R5 empty level 3", {26'b0, c_flt}, 36'h304);
  endtask

  task automatic t_backpressure();
    do_req(VA_B, 1'b0, 4);
    check("R9 result after stall", c_paddr, {PTE_B[31:8], 12'b0} + {18'b0, VA_B[17:0]});
    check("R9 ready again", {35'b0, req_ready}, 36'd1);
  endtask

  // ---------------- main ----------------
  initial begin
    bit timeout;
    timeout = 1'b0;
    cfg_root_ptr = CTP;
    cfg_ctx      = 8'd5;
    repeat (3) @(negedge clk);
    check("R9 no response in reset", {35'b0, rsp_valid}, 36'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    fork
      begin
        t_reset();
        build_tables();
        t_bypass();
        t_l3_load();
        t_l3_store();
        t_large();
        t_faults();
        t_backpressure();
      end
      begin
        repeat (WD_CYC) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule